// File: doc/BRIEF.md
# Interrupt Service Path Selector

This block collects interrupt requests from fourteen sources and picks one to service. It also decides whether the chosen request goes to a microcoded transfer engine or to an ordinary software handler, and it gives the vector address for that choice. Twelve sources arrive as plain event pulses. The other two are combined capture-overrun interrupts. Each of those is built from a pair of capture channels, and each channel in the pair can be masked on its own.

Software sets up three registers through one write port:
- a 16-bit route register, one bit per source;
- a 16-bit interrupt enable register;
- a 4-bit capture-channel enable register.

Software can also load a transfer count for each source. The engine reports each transfer it completes, and each report lowers that source's count by one. When the count of a source runs out, the block clears that source's route bit by itself. From then on the source goes to the software handler until software sets the bit again.

The interrupt controller reads the winning request from combinational outputs. It then pulses the acknowledge input, which removes that request's pending flag.

Top module: `isr_route_sel`

## Requirements
- R1: After reset the route register reads 0x0000, all enables are clear, nothing is pending and `irq_valid` is low.
- R2: Route and enable bits 15 and 2 are reserved. Writes to them are ignored, they always read zero, and `src_req` bits 15 and 2 never produce a request. `src_req` bits 11 and 12 are also ignored.
- R3: Bit map from bit 0 upward: timer1 overflow, timer2 overflow, reserved, ext0, ext1, serial transmit, serial receive, capture 0 to 3, overrun 0/1, overrun 2/3, ext2, ext3. When route bit i is set, a won request for source i gives `irq_to_engine`=1 and vector 0xFF2040 + 2i. When the bit is clear, it gives `irq_to_engine`=0 and vector 0xFF2000 + 2i.
- R4: When several enabled requests are pending, the one with the highest bit index wins.
- R5: `irq_ack` while `irq_valid` is high clears the pending flag of the winner only, and takes effect at the next clock edge. If a new event for that same source arrives in the same cycle, the flag stays set.
- R6: Clearing a source's interrupt enable bit stops the source from being chosen, but its pending flag is kept. Setting the enable bit again makes the request visible.
- R7: Pending bit 11 is set by `cap_ovr[0]` or `cap_ovr[1]`, and pending bit 12 is set by `cap_ovr[2]` or `cap_ovr[3]`. Each channel event counts only while its capture-channel enable bit is set. An event on a masked channel is lost.
- R8: Each `xfer_done` pulse lowers the count of source `xfer_idx` by one. The pulse that lowers a count from 1 to 0 clears that source's route bit at the same clock edge. A pulse for a source whose count is already 0 has no effect.
- R9: A route bit cleared this way stays clear until software writes the route register again.
- R10: If a route-register write and a count-exhaust clear happen in the same cycle, the written value wins. If a count load and a decrement for the same source happen in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register to write: 0 = route, 1 = interrupt enable, 2 = capture-channel enable |
| reg_wdata | input | 16 | Write data (the capture-channel enable register uses bits 3:0) |
| cnt_wr | input | 1 | Transfer count load strobe |
| cnt_idx | input | 4 | Source whose count is loaded |
| cnt_wdata | input | 8 | Count value to load |
| xfer_done | input | 1 | The engine finished one transfer |
| xfer_idx | input | 4 | Source the finished transfer belongs to |
| src_req | input | 16 | Event pulses, one per bit position |
| cap_ovr | input | 4 | Capture channel overrun events |
| irq_ack | input | 1 | Acknowledge of the current winner |
| irq_valid | output | 1 | An enabled request is pending |
| irq_idx | output | 4 | Bit index of the winning source |
| irq_to_engine | output | 1 | 1 = transfer engine, 0 = software handler |
| irq_vector | output | 24 | Vector address of the winner |
| route_q | output | 16 | Current route register |

## Verification
Some behaviours are checked by the embedded properties on every clock cycle:
- the winner really is the highest enabled pending index;
- the route output matches the route bit of the winner;
- an acknowledge produces at most one clear, and it removes the flag;
- a route bit is only ever set by a route write;
- an exhaust clear lands one edge after its cause;
- the counters lower their value by one on each completed transfer.

Other behaviours only show up in the bench's scenarios, because they depend on what the bench drives earlier:
- overrun events on masked channels are lost;
- pending flags survive while their enable is off;
- the vector values match the source numbering;
- the same-cycle conflicts resolve as R5 and R10 describe.

// File: rtl/irs_pkg.sv
// Shared constants for the interrupt service path selector.
// Assumes a fixed 16-position source map with two reserved positions.
package irs_pkg;
    localparam int SRC_N     = 16;
    localparam int IDX_W     = $clog2(SRC_N);
    localparam int VEC_W     = 24;
    localparam int CAP_N     = 4;
    localparam logic [VEC_W-1:0] ENG_BASE = 24'hFF2040;
    localparam logic [VEC_W-1:0] STD_BASE = 24'hFF2000;
    localparam logic [SRC_N-1:0] RSV_MASK = 16'h8004;
    localparam int OVR01_BIT = 11;
    localparam int OVR23_BIT = 12;
    localparam logic [SRC_N-1:0] OVR_MASK = (SRC_N'(1) << OVR01_BIT) | (SRC_N'(1) << OVR23_BIT);

    typedef enum logic [1:0] {
        SEL_ROUTE = 2'd0,
        SEL_INTEN = 2'd1,
        SEL_CAPEN = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irs_regs.sv
// Configuration registers: route, interrupt enable, capture-channel enable.
// Assumes: a route write in the same cycle beats a hardware exhaust clear.
// Reserved positions are forced to zero.
module irs_regs
    import irs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [SRC_N-1:0] wr_data,
    input  logic [SRC_N-1:0] exhaust,
    output logic [SRC_N-1:0] route,
    output logic [SRC_N-1:0] int_en,
    output logic [CAP_N-1:0] cap_en
);
    logic wr_route, wr_inten, wr_capen;

    // Decode which register the write port targets.
    always_comb begin
        wr_route = wr_en && (wr_sel == SEL_ROUTE);
        wr_inten = wr_en && (wr_sel == SEL_INTEN);
        wr_capen = wr_en && (wr_sel == SEL_CAPEN);
    end

    // Route register: a software write wins; otherwise exhausted bits drop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route <= '0;
        else if (wr_route)
            route <= wr_data & ~RSV_MASK;
        else
            route <= route & ~exhaust;
    end

    // Enable registers: written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en <= '0;
            cap_en <= '0;
        end else begin
            if (wr_inten) int_en <= wr_data & ~RSV_MASK;
            if (wr_capen) cap_en <= wr_data[CAP_N-1:0];
        end
    end

    p_rst_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (route == '0 && int_en == '0));

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((route & RSV_MASK) == '0) && ((int_en & RSV_MASK) == '0));

    p_set_only_sw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((route & ~$past(route)) != '0) |-> $past(wr_route));

    p_exhaust_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((exhaust != '0) && !wr_route) |=> ((route & $past(exhaust)) == '0));

    p_sw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_route |=> (route == ($past(wr_data) & ~RSV_MASK)));
endmodule

// File: rtl/irs_xfer_cnt.sv
// Per-source transfer counters.
// Assumes: a load in the same cycle beats a decrement of the same counter.
// A decrement at zero is ignored.
// Raises exhaust[i] for one cycle when source i's count goes from 1 to 0.
module irs_xfer_cnt
    import irs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec_en,
    input  logic [IDX_W-1:0] dec_idx,
    output logic [SRC_N-1:0] exhaust
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_cnt
        if (RSV_MASK[i]) begin : g_rsv
            assign exhaust[i] = 1'b0;
        end else begin : g_live
            logic [CNT_W-1:0] cnt;
            logic ld_hit, dec_hit;

            // Work out whether this slot is loaded or lowered this cycle.
            always_comb begin
                ld_hit  = ld_en && (ld_idx == IDX_W'(i));
                dec_hit = dec_en && (dec_idx == IDX_W'(i)) && (cnt != '0);
            end

            assign exhaust[i] = dec_hit && !ld_hit && (cnt == CNT_W'(1));

            // Count update: a load wins, otherwise decrement while above zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (ld_hit)
                    cnt <= ld_val;
                else if (dec_hit)
                    cnt <= cnt - CNT_W'(1);
            end

            p_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (dec_hit && !ld_hit) |=> (cnt == $past(cnt) - CNT_W'(1)));

            p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ld_hit |=> (cnt == $past(ld_val)));
        end
    end
endmodule

// File: rtl/irs_pending.sv
// Pending flags.
// Combines the capture overrun channels, each gated by its own enable, into
// the two shared overrun positions.
// Assumes: a new event wins over an acknowledge clear of the same source.
module irs_pending
    import irs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_req,
    input  logic [CAP_N-1:0] cap_ovr,
    input  logic [CAP_N-1:0] cap_en,
    input  logic [SRC_N-1:0] clr_vec,
    output logic [SRC_N-1:0] pend
);
    logic [CAP_N-1:0] ovr_gated;
    logic [SRC_N-1:0] set_vec;

    // Build the set vector from direct requests and the gated overrun pairs.
    always_comb begin
        ovr_gated = cap_ovr & cap_en;
        set_vec   = src_req & ~RSV_MASK & ~OVR_MASK;
        set_vec[OVR01_BIT] = ovr_gated[0] | ovr_gated[1];
        set_vec[OVR23_BIT] = ovr_gated[2] | ovr_gated[3];
    end

    // Pending update: clear the acknowledged source, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else
            pend <= (pend & ~clr_vec) | set_vec;
    end

    p_ack_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

    p_set_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    p_rsv_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & RSV_MASK) == '0);
endmodule

// File: rtl/irs_arbiter.sv
// Priority resolution and vector generation.
// The highest enabled pending index wins. The path is read from that
// source's route bit at the time of the grant.
// Assumes: at most one grant per acknowledge cycle.
module irs_arbiter
    import irs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] int_en,
    input  logic [SRC_N-1:0] route,
    input  logic             ack,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic             to_engine,
    output logic [VEC_W-1:0] vector,
    output logic [SRC_N-1:0] clr_vec
);
    logic [SRC_N-1:0] elig;

    // Scan from low to high so the last hit (highest index) remains.
    always_comb begin
        elig  = pend & int_en;
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (elig[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // Path choice, vector address and the one-hot clear for an acknowledge.
    always_comb begin
        to_engine = valid && route[idx];
        vector    = (to_engine ? ENG_BASE : STD_BASE) + (VEC_W'(idx) << 1);
        clr_vec   = (ack && valid) ? (SRC_N'(1) << idx) : '0;
    end

    p_top_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((pend & int_en) >> idx) == SRC_N'(1));

    p_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (to_engine == route[idx]));

    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));
endmodule

// File: rtl/isr_route_sel.sv
// Top of the interrupt service path selector.
// Connects the configuration registers, the transfer counters, the pending
// flags and the arbiter.
// Assumes: all inputs are synchronous to clk.
// The winner outputs are combinational from registered state.
module isr_route_sel
    import irs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [15:0]      reg_wdata,
    input  logic             cnt_wr,
    input  logic [3:0]       cnt_idx,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             xfer_done,
    input  logic [3:0]       xfer_idx,
    input  logic [15:0]      src_req,
    input  logic [3:0]       cap_ovr,
    input  logic             irq_ack,
    output logic             irq_valid,
    output logic [3:0]       irq_idx,
    output logic             irq_to_engine,
    output logic [23:0]      irq_vector,
    output logic [15:0]      route_q
);
    logic [SRC_N-1:0] exhaust, int_en, pend, clr_vec;
    logic [CAP_N-1:0] cap_en;

    irs_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .exhaust (exhaust),
        .route   (route_q),
        .int_en  (int_en),
        .cap_en  (cap_en)
    );

    irs_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (cnt_wr),
        .ld_idx  (cnt_idx),
        .ld_val  (cnt_wdata),
        .dec_en  (xfer_done),
        .dec_idx (xfer_idx),
        .exhaust (exhaust)
    );

    irs_pending u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .cap_ovr (cap_ovr),
        .cap_en  (cap_en),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    irs_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .int_en    (int_en),
        .route     (route_q),
        .ack       (irq_ack),
        .valid     (irq_valid),
        .idx       (irq_idx),
        .to_engine (irq_to_engine),
        .vector    (irq_vector),
        .clr_vec   (clr_vec)
    );
endmodule

// File: tb/tb_isr_route_sel.sv
`timescale 1ns/100ps
module tb_isr_route_sel;
    typedef struct {
        int          kind;   // 0 = winner outputs, 1 = route register
        logic        valid;
        logic [3:0]  idx;
        logic        eng;
        logic [23:0] vec;
        logic [15:0] route;
        string       tag;
    } exp_t;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr, cnt_wr, xfer_done, irq_ack;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata, src_req;
    logic [3:0]  cnt_idx, xfer_idx, cap_ovr;
    logic [7:0]  cnt_wdata;
    logic        irq_valid, irq_to_engine;
    logic [3:0]  irq_idx;
    logic [23:0] irq_vector;
    logic [15:0] route_q;

    int   checks = 0, errors = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    isr_route_sel dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cnt_wr(cnt_wr), .cnt_idx(cnt_idx),
        .cnt_wdata(cnt_wdata), .xfer_done(xfer_done), .xfer_idx(xfer_idx),
        .src_req(src_req), .cap_ovr(cap_ovr), .irq_ack(irq_ack),
        .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_to_engine(irq_to_engine),
        .irq_vector(irq_vector), .route_q(route_q)
    );

    // Monitor: just after each falling edge, compare against queued items.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.kind == 1) begin
                if (route_q !== e.route) begin
                    errors++;
                    $display("FAIL %s route actual=%h expected=%h", e.tag, route_q, e.route);
                end
            end else if (!e.valid) begin
                if (irq_valid !== 1'b0) begin
                    errors++;
                    $display("FAIL %s valid actual=%b expected=0 (idx %0d)", e.tag, irq_valid, irq_idx);
                end
            end else if (irq_valid !== 1'b1 || irq_idx !== e.idx ||
                         irq_to_engine !== e.eng || irq_vector !== e.vec) begin
                errors++;
                $display("FAIL %s actual v=%b idx=%0d eng=%b vec=%h expected v=1 idx=%0d eng=%b vec=%h",
                         e.tag, irq_valid, irq_idx, irq_to_engine, irq_vector, e.idx, e.eng, e.vec);
            end
        end
    end

    task automatic idle();
        reg_wr = 0; reg_sel = 0; reg_wdata = 0; cnt_wr = 0; cnt_idx = 0;
        cnt_wdata = 0; xfer_done = 0; xfer_idx = 0; src_req = 0; cap_ovr = 0; irq_ack = 0;
    endtask

    // Hold the inputs driven so far for one clock edge, then release them.
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        tick();
    endtask

    task automatic exp_irq(input logic v, input int i, input logic eng, input string tag);
        exp_t e;
        e.kind = 0; e.valid = v; e.idx = 4'(i); e.eng = eng;
        e.vec = (eng ? 24'hFF2040 : 24'hFF2000) + 24'(2 * i);
        e.route = 0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic exp_route(input logic [15:0] r, input string tag);
        exp_t e;
        e.kind = 1; e.valid = 0; e.idx = 0; e.eng = 0; e.vec = 0; e.route = r; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic ack();
        irq_ack = 1;
        tick();
    endtask

    task automatic done(input int i);
        xfer_done = 1; xfer_idx = 4'(i);
        tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        exp_route(16'h0000, "R1"); exp_irq(0, 0, 0, "R1");

        wr_reg(0, 16'hFFFF); exp_route(16'h7FFB, "R2");
        wr_reg(0, 16'h0000); exp_route(16'h0000, "R2");
        wr_reg(1, 16'hFFFF);
        wr_reg(2, 16'h000F);

        // R2: reserved and overrun positions of src_req do nothing
        src_req = 16'h9804; tick(); exp_irq(0, 0, 0, "R2");

        // R3: software handler path for ext0
        src_req = 16'h0008; tick(); exp_irq(1, 3, 0, "R3");
        ack(); exp_irq(0, 0, 0, "R5");

        // R3: engine path for serial transmit
        wr_reg(0, 16'h0020);
        src_req = 16'h0020; tick(); exp_irq(1, 5, 1, "R3");
        ack(); exp_irq(0, 0, 0, "R5");

        // R4: priority among 0, 6, 14
        src_req = 16'h4041; tick(); exp_irq(1, 14, 0, "R4");
        ack(); exp_irq(1, 6, 0, "R4");
        ack(); exp_irq(1, 0, 0, "R4");
        ack(); exp_irq(0, 0, 0, "R5");

        // R5: a new event in the acknowledge cycle keeps the flag
        src_req = 16'h0010; tick(); exp_irq(1, 4, 0, "R5");
        irq_ack = 1; src_req = 16'h0010; tick(); exp_irq(1, 4, 0, "R5");
        ack(); exp_irq(0, 0, 0, "R5");

        // R6: a masked source keeps its pending flag
        wr_reg(1, 16'h7F7B);
        src_req = 16'h0080; tick(); exp_irq(0, 0, 0, "R6");
        wr_reg(1, 16'hFFFF); exp_irq(1, 7, 0, "R6");
        ack(); exp_irq(0, 0, 0, "R6");

        // R7: overrun pairs with per-channel gating
        wr_reg(2, 16'h0001);
        cap_ovr = 4'b0010; tick(); exp_irq(0, 0, 0, "R7");
        wr_reg(0, 16'h0800);
        cap_ovr = 4'b0001; tick(); exp_irq(1, 11, 1, "R7");
        ack(); exp_irq(0, 0, 0, "R7");
        wr_reg(2, 16'h0004);
        cap_ovr = 4'b1000; tick(); exp_irq(0, 0, 0, "R7");
        cap_ovr = 4'b0100; tick(); exp_irq(1, 12, 0, "R7");
        ack(); exp_irq(0, 0, 0, "R7");

        // R8: count exhaustion clears the route bit
        wr_reg(0, 16'h4000);
        cnt_wr = 1; cnt_idx = 14; cnt_wdata = 8'd2; tick();
        done(14); exp_route(16'h4000, "R8");
        done(14); exp_route(16'h0000, "R8");
        done(14); exp_route(16'h0000, "R8");
        src_req = 16'h4000; tick(); exp_irq(1, 14, 0, "R8");
        ack();

        // R9: the bit stays clear until software sets it again
        tick(); tick(); exp_route(16'h0000, "R9");
        wr_reg(0, 16'h4000); exp_route(16'h4000, "R9");

        // R10: a route write beats the exhaust clear in the same cycle
        cnt_wr = 1; cnt_idx = 14; cnt_wdata = 8'd1; tick();
        xfer_done = 1; xfer_idx = 14; reg_wr = 1; reg_sel = 0; reg_wdata = 16'h4000; tick();
        exp_route(16'h4000, "R10");
        done(14); exp_route(16'h4000, "R10");

        // R10: a count load beats the decrement in the same cycle
        cnt_wr = 1; cnt_idx = 14; cnt_wdata = 8'd3; xfer_done = 1; xfer_idx = 14; tick();
        done(14); done(14); exp_route(16'h4000, "R10");
        done(14); exp_route(16'h0000, "R10");

        tick(); tick();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule